// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block is the SPI master for an external multichannel successive-approximation converter. One trigger starts one scan. At that moment the block captures a channel-enable mask, a power-mode value and a range selection. It then works through the enabled channels from the lowest number to the highest. For each channel it sends a 16-bit command frame and reads back a 16-bit result frame.

The converter is pipelined, so the result for a command comes back in the frame after that command. The block therefore sends one extra frame at the end of the scan and matches each returned result to the command that produced it. Each result frame carries a channel tag in its top four bits, and the block compares that tag with the channel it requested. Every result comes out as a one-cycle sample strobe with its channel number, the data and an error flag. A done strobe closes the scan and reports whether any tag in the scan was wrong.

Serial clock division, the minimum chip-select high time, the number of channels (4 or 8) and the result width (8, 10 or 12 bits) are all parameters.

Top module: `adc_scan_seq`

## Requirements
- R1: Each command frame is a 12-bit control word shifted left by 4 and sent MSB first. The lowest four frame bits are zero. The control word bits are:
  - bit 11 is always 1 (write enable);
  - bits 8:6 hold the channel number;
  - bits 5:4 hold `pwr_mode` (1 = auto shutdown, 2 = full shutdown, 3 = normal operation);
  - bit 1 equals `range_ref` (1 means the full scale equals the reference, 0 means double the reference);
  - bit 0 is always 1 (straight binary coding);
  - bits 10, 9, 3 and 2 are always 0, so the split sequence field (high bit at 10, low bit at 3) is always written as "no sequence".
- R2: A scan sends one command per set bit of `ch_mask`, in ascending channel order, skipping clear bits. It then sends one extra frame that repeats the last command, for popcount(mask)+1 frames in total.
- R3: Serial timing follows these rules:
  - `sclk` is high whenever `cs_n` is high;
  - every frame has exactly 16 falling `sclk` edges;
  - `mosi` changes only while `sclk` is high;
  - `miso` is sampled on falling `sclk` edges;
  - each half period of `sclk` lasts CLK_DIV clock cycles.
- R4: `cs_n` rises after every frame and stays high for at least CS_HIGH clock cycles before it falls again. No frame follows the final one of a scan, and `cs_n` is high when `scan_done` pulses.
- R5: The result frame received during frame k+1 is reported as the sample for the k-th command. `smp_chan` carries that command's channel, and `smp_data` carries result bits [11 -: DATA_BITS], i.e. the data left-justified below the tag. The result of the first frame of a scan is discarded, so a scan yields exactly popcount(mask) samples.
- R6: If the top four bits of a result differ from the requested channel number, `smp_err` is high with that sample. `scan_err` is high with `scan_done` if any sample in the scan had a tag error.
- R7: `scan_done` pulses in the same cycle as the final sample's `smp_valid`, and exactly once per scan.
- R8: `busy` goes high in the cycle after an accepted trigger and stays high until the serial engine is idle again. A trigger that arrives while `busy` is high is ignored: it adds no frames and no samples.
- R9: A trigger with a zero mask produces `scan_done` (with `scan_err` low) in the next cycle. It sends no frame and leaves `busy` low.
- R10: After reset the outputs are in these states:
  - `cs_n` and `sclk` are high;
  - `busy` is low;
  - `smp_valid` and `scan_done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Scan trigger, accepted when not busy |
| ch_mask | input | NUM_CH | Channel-enable mask, captured on trigger |
| pwr_mode | input | 2 | Power-mode field for the commands |
| range_ref | input | 1 | Range select: 1 = full scale equals the reference |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Command data to the converter |
| miso | input | 1 | Result data from the converter |
| busy | output | 1 | Scan in progress |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_chan | output | 3 | Channel of the sample |
| smp_data | output | DATA_BITS | Sample value |
| smp_err | output | 1 | Tag mismatch on this sample |
| scan_done | output | 1 | One-cycle end-of-scan strobe |
| scan_err | output | 1 | Some sample of the scan had a tag error |

## Verification
`busy`, and `scan_done` for a zero-mask trigger, are due one clock after the edge that samples the trigger. The bench drives that trigger on a falling clock edge and reads these outputs on the following falling edge.

Chip select stays low for 33*CLK_DIV cycles per frame. Each sample strobe comes one cycle after `cs_n` rises, so a scan of n channels ends within a bounded number of cycles. The bench waits for `busy` to fall under a cycle limit instead of assuming one fixed count.

A behavioural converter on the serial pins records every command frame and counts the clock edges in each frame. It returns tagged results one frame late. Those recorded frames, together with samples collected on falling clock edges, are compared against values computed from the mask and settings.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int FRAME_W = 16;
    localparam int CTRL_W  = 12;
    localparam int TAG_W   = 4;
    localparam int CHAN_W  = 3;

    // Command layout; field positions are decoded by the converter.
    typedef struct packed {
        logic              wr_en;     // 11
        logic              seq_hi;    // 10
        logic              rsv9;      // 9
        logic [CHAN_W-1:0] chan;      // 8:6
        logic [1:0]        pmode;     // 5:4
        logic              seq_lo;    // 3
        logic              rsv2;      // 2
        logic              rng;       // 1
        logic              straight;  // 0
    } ctrl_word_t;

    typedef enum logic [2:0] {
        E_IDLE, E_LEAD, E_LOW, E_HIGH, E_TAIL, E_GAP
    } eng_state_e;

    typedef enum logic [1:0] {
        S_IDLE, S_ISSUE, S_WAIT
    } seq_state_e;

    function automatic logic [FRAME_W-1:0] make_cmd_frame(
        input logic [CHAN_W-1:0] ch,
        input logic [1:0]        pm,
        input logic              rng
    );
        ctrl_word_t w;
        w          = '0;
        w.wr_en    = 1'b1;
        w.chan     = ch;
        w.pmode    = pm;
        w.rng      = rng;
        w.straight = 1'b1;
        return {w, {(FRAME_W - CTRL_W){1'b0}}};
    endfunction

endpackage

// File: rtl/adc_spi_frame_engine.sv
module adc_spi_frame_engine
    import adc_scan_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int CS_HIGH = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_frame,
    output logic               ready,
    output logic               done,
    output logic [FRAME_W-1:0] rx_frame,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi,
    input  logic               miso
);
    localparam int DIV_W = $clog2(CLK_DIV + 1);
    localparam int GAP_W = $clog2(CS_HIGH + 1);
    localparam int CNT_W = (DIV_W > GAP_W) ? DIV_W : GAP_W;
    localparam int BIT_W = $clog2(FRAME_W);

    eng_state_e         st;
    logic [CNT_W-1:0]   cnt;
    logic [BIT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] tx_sh;
    logic [FRAME_W-1:0] rx_sh;
    logic               sclk_q;
    logic               cs_q;
    logic               done_q;
    logic [FRAME_W-1:0] rx_q;
    logic               half_end;
    logic               gap_end;

    assign half_end = (cnt == CNT_W'(CLK_DIV - 1));
    assign gap_end  = (cnt == CNT_W'(CS_HIGH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= E_IDLE;
            cnt     <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            sclk_q  <= 1'b1;
            cs_q    <= 1'b1;
            done_q  <= 1'b0;
            rx_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (st)
                E_IDLE: begin
                    if (start) begin
                        tx_sh   <= tx_frame;
                        cs_q    <= 1'b0;
                        cnt     <= '0;
                        bit_cnt <= '0;
                        st      <= E_LEAD;
                    end
                end
                E_LEAD, E_HIGH: begin
                    if (half_end) begin
                        cnt    <= '0;
                        sclk_q <= 1'b0;
                        rx_sh  <= {rx_sh[FRAME_W-2:0], miso};
                        st     <= E_LOW;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                E_LOW: begin
                    if (half_end) begin
                        cnt    <= '0;
                        sclk_q <= 1'b1;
                        if (bit_cnt == BIT_W'(FRAME_W - 1)) begin
                            st <= E_TAIL;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            tx_sh   <= {tx_sh[FRAME_W-2:0], 1'b0};
                            st      <= E_HIGH;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                E_TAIL: begin
                    if (half_end) begin
                        cnt    <= '0;
                        cs_q   <= 1'b1;
                        done_q <= 1'b1;
                        rx_q   <= rx_sh;
                        st     <= E_GAP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                E_GAP: begin
                    if (gap_end) begin
                        cnt <= '0;
                        st  <= E_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= E_IDLE;
            endcase
        end
    end

    assign ready    = (st == E_IDLE);
    assign done     = done_q;
    assign rx_frame = rx_q;
    assign sclk     = sclk_q;
    assign cs_n     = cs_q;
    assign mosi     = tx_sh[FRAME_W-1];

endmodule

// File: rtl/adc_chan_picker.sv
module adc_chan_picker
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] remain,
    output logic              any,
    output logic [CHAN_W-1:0] idx,
    output logic [NUM_CH-1:0] rest
);
    logic [NUM_CH-1:0] lowest;

    assign lowest = remain & (~remain + 1'b1);
    assign rest   = remain & ~lowest;
    assign any    = |remain;

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (lowest[i]) idx = CHAN_W'(i);
        end
    end

endmodule

// File: rtl/adc_result_check.sv
module adc_result_check
    import adc_scan_pkg::*;
#(
    parameter int DATA_BITS = 12
) (
    input  logic [FRAME_W-1:0]   rx,
    input  logic [CHAN_W-1:0]    want_ch,
    output logic [DATA_BITS-1:0] value,
    output logic                 tag_ok
);
    localparam int VAL_MSB = FRAME_W - TAG_W - 1;
    localparam int VAL_LSB = VAL_MSB - DATA_BITS + 1;

    assign value  = rx[VAL_MSB:VAL_LSB];
    assign tag_ok = (rx[FRAME_W-1:FRAME_W-TAG_W] == TAG_W'(want_ch));

    generate
        if (VAL_LSB > 0) begin : g_pad
            logic unused_pad;
            assign unused_pad = ^rx[VAL_LSB-1:0];
        end
    endgenerate

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int DATA_BITS = 12,
    parameter int CLK_DIV   = 2,
    parameter int CS_HIGH   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 trig,
    input  logic [NUM_CH-1:0]    ch_mask,
    input  logic [1:0]           pwr_mode,
    input  logic                 range_ref,
    output logic                 sclk,
    output logic                 cs_n,
    output logic                 mosi,
    input  logic                 miso,
    output logic                 busy,
    output logic                 smp_valid,
    output logic [CHAN_W-1:0]    smp_chan,
    output logic [DATA_BITS-1:0] smp_data,
    output logic                 smp_err,
    output logic                 scan_done,
    output logic                 scan_err
);
    seq_state_e          st;
    logic [NUM_CH-1:0]   remain;
    logic [1:0]          pm_q;
    logic                rng_q;
    logic [CHAN_W-1:0]   sent_ch;
    logic [CHAN_W-1:0]   prev_ch;
    logic                have_prev;
    logic                last_q;
    logic                err_acc;

    logic                pick_any;
    logic [CHAN_W-1:0]   pick_idx;
    logic [NUM_CH-1:0]   pick_rest;

    logic                eng_start;
    logic                eng_ready;
    logic                eng_done;
    logic [FRAME_W-1:0]  eng_tx;
    logic [FRAME_W-1:0]  eng_rx;

    logic [DATA_BITS-1:0] chk_value;
    logic                 chk_ok;

    logic                 smp_valid_q;
    logic [CHAN_W-1:0]    smp_chan_q;
    logic [DATA_BITS-1:0] smp_data_q;
    logic                 smp_err_q;
    logic                 done_q;
    logic                 serr_q;
    logic                 busy_w;

    adc_chan_picker #(.NUM_CH(NUM_CH)) u_pick (
        .remain (remain),
        .any    (pick_any),
        .idx    (pick_idx),
        .rest   (pick_rest)
    );

    assign eng_start = (st == S_ISSUE) && eng_ready;
    assign eng_tx    = make_cmd_frame(pick_any ? pick_idx : sent_ch, pm_q, rng_q);

    adc_spi_frame_engine #(.CLK_DIV(CLK_DIV), .CS_HIGH(CS_HIGH)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (eng_start),
        .tx_frame (eng_tx),
        .ready    (eng_ready),
        .done     (eng_done),
        .rx_frame (eng_rx),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .mosi     (mosi),
        .miso     (miso)
    );

    adc_result_check #(.DATA_BITS(DATA_BITS)) u_chk_res (
        .rx      (eng_rx),
        .want_ch (prev_ch),
        .value   (chk_value),
        .tag_ok  (chk_ok)
    );

    assign busy_w = (st != S_IDLE) || !eng_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= S_IDLE;
            remain      <= '0;
            pm_q        <= '0;
            rng_q       <= 1'b0;
            sent_ch     <= '0;
            prev_ch     <= '0;
            have_prev   <= 1'b0;
            last_q      <= 1'b0;
            err_acc     <= 1'b0;
            smp_valid_q <= 1'b0;
            smp_chan_q  <= '0;
            smp_data_q  <= '0;
            smp_err_q   <= 1'b0;
            done_q      <= 1'b0;
            serr_q      <= 1'b0;
        end else begin
            smp_valid_q <= 1'b0;
            smp_err_q   <= 1'b0;
            done_q      <= 1'b0;
            serr_q      <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (trig && !busy_w) begin
                        if (ch_mask == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            remain    <= ch_mask;
                            pm_q      <= pwr_mode;
                            rng_q     <= range_ref;
                            have_prev <= 1'b0;
                            err_acc   <= 1'b0;
                            st        <= S_ISSUE;
                        end
                    end
                end
                S_ISSUE: begin
                    if (eng_ready) begin
                        if (pick_any) sent_ch <= pick_idx;
                        remain <= pick_rest;
                        last_q <= !pick_any;
                        st     <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (eng_done) begin
                        if (have_prev) begin
                            smp_valid_q <= 1'b1;
                            smp_chan_q  <= prev_ch;
                            smp_data_q  <= chk_value;
                            smp_err_q   <= !chk_ok;
                            err_acc     <= err_acc | !chk_ok;
                        end
                        prev_ch   <= sent_ch;
                        have_prev <= 1'b1;
                        if (last_q) begin
                            done_q <= 1'b1;
                            serr_q <= err_acc | (have_prev & !chk_ok);
                            st     <= S_IDLE;
                        end else begin
                            st <= S_ISSUE;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy      = busy_w;
    assign smp_valid = smp_valid_q;
    assign smp_chan  = smp_chan_q;
    assign smp_data  = smp_data_q;
    assign smp_err   = smp_err_q;
    assign scan_done = done_q;
    assign scan_err  = serr_q;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
    parameter int CS_HIGH = 2
) (
    input logic clk,
    input logic rst,
    input logic trig,
    input logic sclk,
    input logic cs_n,
    input logic mosi,
    input logic busy,
    input logic smp_valid,
    input logic smp_err,
    input logic scan_done,
    input logic scan_err
);
    localparam int HW = $clog2(CS_HIGH + 1) + 1;

    logic [HW-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= HW'(CS_HIGH);
        end else if (!cs_n) begin
            hi_run <= '0;
        end else if (hi_run < HW'(CS_HIGH)) begin
            hi_run <= hi_run + 1'b1;
        end
    end

    // R3: serial clock idles high while deselected
    a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    // R3: data line holds through each low phase
    a_r3_mosi_steady_low: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !sclk && $past(!sclk) && $past(!cs_n)) |-> $stable(mosi));

    // R4: minimum deselect time before a new frame
    a_r4_cs_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (hi_run >= HW'(CS_HIGH)));

    // R4: no frame in flight at end of scan
    a_r4_done_deselected: assert property (@(posedge clk) disable iff (rst)
        scan_done |-> cs_n);

    // R6: error flags only accompany their strobes
    a_r6_err_with_sample: assert property (@(posedge clk) disable iff (rst)
        smp_err |-> smp_valid);

    a_r6_scan_err_with_done: assert property (@(posedge clk) disable iff (rst)
        scan_err |-> scan_done);

    // R8: busy only starts from a trigger; samples only inside a scan
    a_r8_busy_from_trig: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(trig));

    a_r8_sample_in_scan: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> busy);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CS_HIGH(CS_HIGH)) u_seq_chk (
    .clk       (clk),
    .rst       (rst),
    .trig      (trig),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .busy      (busy),
    .smp_valid (smp_valid),
    .smp_err   (smp_err),
    .scan_done (scan_done),
    .scan_err  (scan_err)
);

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 8;
    localparam int DATA_BITS  = 10;
    localparam int CLK_DIV    = 2;
    localparam int CS_HIGH    = 3;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 trig = 1'b0;
    logic [NUM_CH-1:0]    ch_mask = '0;
    logic [1:0]           pwr_mode = 2'd3;
    logic                 range_ref = 1'b1;
    logic                 sclk, cs_n, mosi;
    logic                 miso = 1'b0;
    logic                 busy, smp_valid, smp_err, scan_done, scan_err;
    logic [2:0]           smp_chan;
    logic [DATA_BITS-1:0] smp_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_scan_seq #(.NUM_CH(NUM_CH), .DATA_BITS(DATA_BITS), .CLK_DIV(CLK_DIV),
                   .CS_HIGH(CS_HIGH)) dut (
        .clk(clk), .rst(rst), .trig(trig), .ch_mask(ch_mask), .pwr_mode(pwr_mode),
        .range_ref(range_ref), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .busy(busy), .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data),
        .smp_err(smp_err), .scan_done(scan_done), .scan_err(scan_err)
    );

    // Behavioural converter: pipelined, tag in top four bits.
    logic [15:0] m_out_sh = '0;
    logic [15:0] m_in_sh  = '0;
    logic [15:0] m_next   = '0;
    logic [15:0] m_cmd [0:15];
    int          m_falls = 0;
    int          m_fcnt = 0;
    int          m_falls_bad = 0;
    int          err_frame = 0;
    logic [DATA_BITS-1:0] adc_val [0:7];

    always @(negedge cs_n) begin
        m_out_sh = m_next;
        miso     = m_next[15];
        m_falls  = 0;
    end

    always @(posedge sclk) if (cs_n === 1'b0) begin
        m_out_sh = {m_out_sh[14:0], 1'b0};
        miso     = m_out_sh[15];
    end

    always @(negedge sclk) if (cs_n === 1'b0) begin
        m_in_sh = {m_in_sh[14:0], mosi};
        m_falls++;
    end

    always @(posedge cs_n) begin
        logic [2:0] ch;
        logic [3:0] tag;
        if (m_fcnt < 16) m_cmd[m_fcnt] = m_in_sh;
        if (m_falls != 16) m_falls_bad++;
        m_fcnt++;
        ch  = m_in_sh[12:10];
        tag = {1'b0, ch};
        if (m_fcnt == err_frame) tag = tag ^ 4'h8;
        m_next = {tag, 12'(adc_val[ch]) << (12 - DATA_BITS)};
    end

    // Monitor on falling clock edges
    int         s_n = 0;
    logic [2:0] s_ch  [0:15];
    logic [DATA_BITS-1:0] s_dat [0:15];
    logic       s_err [0:15];
    int         done_cnt = 0;
    logic       done_err = 1'b0;
    logic       done_with_valid = 1'b0;
    int         idle_bad = 0;
    int         gap_bad = 0;
    int         hi_run = 100;
    logic       cs_prev = 1'b1;

    always @(negedge clk) if (!rst) begin
        if (cs_n && !sclk) idle_bad++;
        if (cs_prev && !cs_n && hi_run < CS_HIGH) gap_bad++;
        hi_run  = cs_n ? hi_run + 1 : 0;
        cs_prev = cs_n;
        if (smp_valid) begin
            if (s_n < 16) begin
                s_ch[s_n] = smp_chan; s_dat[s_n] = smp_data; s_err[s_n] = smp_err;
            end
            s_n++;
        end
        if (scan_done) begin
            done_cnt++;
            done_err        = scan_err;
            done_with_valid = smp_valid;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_frame(input int ch, input logic [1:0] pm,
                                              input logic rng);
        logic [11:0] c;
        c = 12'h801 | (12'(ch) << 6) | (12'(pm) << 4) | (rng ? 12'h002 : 12'h000);
        return {c, 4'h0};
    endfunction

    task automatic run_scan(input logic [7:0] mask, input logic [1:0] pm,
                            input logic rng, input int efr, input bit extra_trig);
        int exp_ch [0:7];
        int n;
        int bad;
        int lim;
        n = 0;
        for (int c = 0; c < 8; c++) begin
            adc_val[c] = DATA_BITS'($urandom);
            if (mask[c]) begin exp_ch[n] = c; n++; end
        end
        @(negedge clk);
        err_frame = efr; m_fcnt = 0; m_falls_bad = 0; s_n = 0; done_cnt = 0;
        idle_bad = 0; gap_bad = 0;
        ch_mask = mask; pwr_mode = pm; range_ref = rng; trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        if (n == 0) begin
            check(scan_done === 1'b1 && scan_err === 1'b0, "R9", "done next cycle",
                  {scan_done, scan_err}, 2'b10);
            check(busy === 1'b0, "R9", "busy stays low", busy, 0);
        end else begin
            check(busy === 1'b1, "R8", "busy after trigger", busy, 1);
        end
        if (extra_trig) begin
            repeat (40) @(negedge clk);
            ch_mask = 8'hFF; trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
        end
        lim = 0;
        while (busy !== 1'b0 && lim < 20000) begin @(negedge clk); lim++; end
        repeat (CS_HIGH + 4) @(negedge clk);
        check(lim < 20000, "R8", "busy falls", lim, 0);
        check(m_fcnt == ((n == 0) ? 0 : n + 1), "R2", "frame count", m_fcnt,
              (n == 0) ? 0 : n + 1);
        if (n > 0) begin
            check(m_cmd[0] == exp_frame(exp_ch[0], pm, rng), "R1", "first command",
                  m_cmd[0], exp_frame(exp_ch[0], pm, rng));
            bad = 0;
            for (int k = 0; k <= n && k < 16; k++) begin
                if (m_cmd[k] != exp_frame(exp_ch[(k < n) ? k : n - 1], pm, rng)) bad++;
            end
            check(bad == 0, "R2", "command order", bad, 0);
            check(m_falls_bad == 0 && idle_bad == 0, "R3", "serial edges",
                  m_falls_bad + idle_bad, 0);
            check(gap_bad == 0, "R4", "deselect gap", gap_bad, 0);
            check(s_n == n, "R5", "sample count", s_n, n);
            bad = 0;
            for (int k = 0; k < n && k < 16; k++) begin
                if (s_ch[k] != 3'(exp_ch[k]) || s_dat[k] != adc_val[exp_ch[k]]) bad++;
            end
            check(bad == 0, "R5", "sample content", bad, 0);
            bad = 0;
            for (int k = 0; k < n && k < 16; k++) begin
                if (s_err[k] != (efr == k + 1)) bad++;
            end
            check(bad == 0, "R6", "sample error flags", bad, 0);
            check(done_err == (efr >= 1 && efr <= n), "R6", "scan error", done_err,
                  (efr >= 1 && efr <= n));
            check(done_cnt == 1 && done_with_valid, "R7", "done with last sample",
                  {done_cnt[7:0], 7'b0, done_with_valid}, 16'h0101);
        end else begin
            check(done_cnt == 1, "R9", "one done strobe", done_cnt, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R0 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n === 1'b1 && sclk === 1'b1, "R10", "serial idle", {cs_n, sclk}, 2'b11);
        check(busy === 1'b0 && smp_valid === 1'b0 && scan_done === 1'b0, "R10",
              "strobes low", {busy, smp_valid, scan_done}, 0);

        run_scan(8'h01, 2'd3, 1'b1, 0, 1'b0);
        run_scan(8'h80, 2'd1, 1'b0, 0, 1'b0);
        run_scan(8'hFF, 2'd2, 1'b1, 0, 1'b0);
        run_scan(8'hA5, 2'd3, 1'b0, 2, 1'b0);
        run_scan(8'h00, 2'd3, 1'b1, 0, 1'b0);
        run_scan(8'h12, 2'd3, 1'b1, 0, 1'b1);
        run_scan(8'h0C, 2'd3, 1'b1, 2, 1'b0);
        for (int i = 0; i < 20; i++) begin
            logic [7:0] m;
            int ef;
            m  = 8'($urandom);
            ef = ($urandom % 3 == 0) ? 1 + ($urandom % 8) : 0;
            run_scan(m, 2'($urandom), 1'($urandom), ef, 1'($urandom % 4 == 0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule